// File: doc/BRIEF.md
# RC Time-Constant Meter

This block turns the discharge time of an analog replica integrator into a digital correction factor. When a measurement begins, the integrator is preset to its upper reference and starts to ramp down. A clocked comparator goes high once the ramp has fallen below a lower threshold. The block counts clock periods from the accepted start until that comparator level is confirmed. It then divides the count by a programmed nominal count and presents the quotient as an unsigned fixed-point ratio. Downstream logic scales the pre-emphasis filter coefficients by this ratio.

A measurement is normally launched at the start of a calibration slot and runs while the synthesizer relocks. With the sampling clock at about 104 MHz and a nominal crossing near 4 µs, the nominal count is around 416. A count that reaches four times the nominal value without a crossing ends the measurement with an overflow flag instead of a ratio.

Top module: `rc_tau_meter`

## Requirements
- R1: While reset is asserted and after it is released, count_o and ratio_o are 0, and done_o and ovf_o are low.
- R2: A start_i high sampled while idle begins a measurement. count_o is the number of rising edges from the edge that samples start_i up to the edge that first samples cmp_i high, plus 2. The extra 2 comes from synchronizer and qualifier latency.
- R3: A crossing is accepted only when the synchronized comparator bit is high on two consecutive samples. A single-sample pulse on cmp_i has no effect on the count.
- R4: ratio_o equals floor(count_o * 2^14 / nominal) as an unsigned 16-bit value with 2 integer bits and 14 fraction bits. A value of 16384 means 1.0.
- R5: done_o is high for exactly one cycle, following the 19th rising edge after the edge that first samples cmp_i high. ratio_o is valid from that cycle and holds until the next result.
- R6: If the internal count reaches 4 × nominal with no accepted crossing, the next edge ends the measurement. That edge sets ovf_o, sets count_o to 4 × nominal and sets ratio_o to 16'hFFFF, and done_o is not raised. ovf_o then stays high until the next accepted start. A nominal of 0 overflows on the second edge after start.
- R7: start_i is ignored while a measurement is counting or dividing.
- R8: The nominal value is captured when start is accepted. Later changes on nominal_i do not affect the running result.
- R9: After done or overflow the block is idle, and it accepts a new start. The accepting edge clears ovf_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a measurement when idle |
| cmp_i | input | 1 | Asynchronous comparator bit, high once the ramp is below threshold |
| nominal_i | input | NOM_W | Expected count for a nominal time constant |
| count_o | output | NOM_W+2 | Measured count of clock periods |
| ratio_o | output | FRAC_W+2 | Measured over nominal count, unsigned Q2.14 |
| done_o | output | 1 | One-cycle pulse when ratio_o is updated |
| ovf_o | output | 1 | Count reached four times nominal without a crossing |

## Verification
Each result is timed from the edge at which cmp_i is first sampled high. The count is latched three edges later. The ratio and the done pulse follow after another sixteen division edges, so done appears 19 edges after that first sample. Overflow appears on the edge after the internal count reaches four times nominal. The tasks drive inputs on falling edges, number every rising edge since the start edge, and compare done_o, count_o, ratio_o and ovf_o at the falling edge that follows the exact edge each one is due. Being one cycle early or late is therefore reported as a failure, just like a wrong value.

// File: rtl/rc_tau_meter.sv
module rc_tau_meter #(
  parameter int NOM_W  = 12,
  parameter int FRAC_W = 14,
  localparam int CNT_W = NOM_W + 2,
  localparam int Q_W   = FRAC_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  input  logic [NOM_W-1:0] nominal_i,
  output logic [CNT_W-1:0] count_o,
  output logic [Q_W-1:0]   ratio_o,
  output logic             done_o,
  output logic             ovf_o
);

  localparam int STEP_W = $clog2(Q_W);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(Q_W - 1);

  typedef enum logic [1:0] {IDLE, COUNT, DIV} state_t;

  state_t              state;
  logic                s1, s2, s3;
  logic [NOM_W-1:0]    nom_q;
  logic [CNT_W-1:0]    cnt;
  logic [NOM_W-1:0]    rem;
  logic [Q_W-1:0]      shr, quo;
  logic [STEP_W-1:0]   step;

  logic [CNT_W-1:0]    lim;
  logic                crossed, busy, fit;
  logic [NOM_W:0]      trial;
  logic [NOM_W-1:0]    diff;

  assign lim     = {nom_q, 2'b00};
  assign crossed = s2 & s3;
  assign busy    = (state != IDLE);
  assign trial   = {rem, shr[Q_W-1]};
  assign fit     = trial >= {1'b0, nom_q};
  assign diff    = trial[NOM_W-1:0] - nom_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= IDLE;
      s1      <= 1'b0;
      s2      <= 1'b0;
      s3      <= 1'b0;
      nom_q   <= '0;
      cnt     <= '0;
      rem     <= '0;
      shr     <= '0;
      quo     <= '0;
      step    <= '0;
      count_o <= '0;
      ratio_o <= '0;
      done_o  <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      s1     <= cmp_i;
      s2     <= s1;
      s3     <= s2;
      done_o <= 1'b0;
      case (state)
        IDLE: begin
          if (start_i) begin
            nom_q <= nominal_i;
            cnt   <= '0;
            ovf_o <= 1'b0;
            state <= COUNT;
          end
        end
        COUNT: begin
          if (cnt >= lim) begin
            ovf_o   <= 1'b1;
            count_o <= cnt;
            ratio_o <= '1;
            state   <= IDLE;
          end else if (crossed) begin
            count_o <= cnt;
            rem     <= cnt[CNT_W-1:2];
            shr     <= {cnt[1:0], {FRAC_W{1'b0}}};
            quo     <= '0;
            step    <= '0;
            state   <= DIV;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        DIV: begin
          rem  <= fit ? diff : trial[NOM_W-1:0];
          shr  <= shr << 1;
          quo  <= {quo[Q_W-2:0], fit};
          step <= step + 1'b1;
          if (step == LAST) begin
            ratio_o <= {quo[Q_W-2:0], fit};
            done_o  <= 1'b1;
            state   <= IDLE;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rc_tau_meter_chk.sv
module rc_tau_meter_chk #(
  parameter int NOM_W  = 12,
  parameter int FRAC_W = 14
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_i,
  input logic                  busy,
  input logic                  done_o,
  input logic                  ovf_o,
  input logic [NOM_W+1:0]      count_o,
  input logic [FRAC_W+1:0]     ratio_o,
  input logic [NOM_W-1:0]      nom_q
);

  localparam int PW = FRAC_W + 2 + NOM_W + 1;

  logic [PW-1:0] lo, hi, tgt;
  assign lo  = PW'(ratio_o) * PW'(nom_q);
  assign hi  = lo + PW'(nom_q);
  assign tgt = PW'(count_o) << FRAC_W;

  // R4
  ratio_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lo <= tgt) && (hi > tgt));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy);

  // R6
  ovf_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> !done_o && (ratio_o == '1) && (count_o == {nom_q, 2'b00}));

  // R9
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_i) |=> busy && !ovf_o);

endmodule

bind rc_tau_meter rc_tau_meter_chk #(.NOM_W(NOM_W), .FRAC_W(FRAC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy(busy), .done_o(done_o),
  .ovf_o(ovf_o), .count_o(count_o), .ratio_o(ratio_o), .nom_q(nom_q)
);

// File: tb/rc_tau_meter_tb_top.sv
module rc_tau_meter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        cmp_i = 1'b0;
  logic [11:0] nominal_i = '0;
  logic [13:0] count_o;
  logic [15:0] ratio_o;
  logic        done_o, ovf_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  rc_tau_meter dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .nominal_i(nominal_i), .count_o(count_o), .ratio_o(ratio_o),
    .done_o(done_o), .ovf_o(ovf_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=200000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(longint'(count_o) == 0, "R1 count in reset", longint'(count_o), 0);
    chk(done_o == 1'b0 && ovf_o == 1'b0, "R1 flags in reset", {done_o, ovf_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(longint'(ratio_o) == 0, "R1 ratio after reset", longint'(ratio_o), 0);
    chk(done_o == 1'b0 && ovf_o == 1'b0, "R1 flags after reset", {done_o, ovf_o}, 0);
  endtask

  // d >= 1: cmp_i rises just after the d-th edge following the start edge
  task automatic measure(input int nom, input int d, input int glitch,
                         input int restart, input int new_nom, input string tag);
    int e = 0;
    int e_done = -1;
    longint exp_cnt = longint'(d) + 3;
    longint exp_rat = (exp_cnt * 16384) / nom;
    @(negedge clk);
    nominal_i = nom[11:0];
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk(ovf_o == 1'b0, {"R9 ovf cleared by start ", tag}, ovf_o, 0);
    while (e_done < 0 && e < d + 60) begin
      @(posedge clk);
      e++;
      @(negedge clk);
      if (done_o) e_done = e;
      if (e == d) cmp_i = 1'b1;
      if (glitch > 0 && e == glitch) cmp_i = 1'b1;
      if (glitch > 0 && e == glitch + 1) cmp_i = 1'b0;
      if (restart > 0 && e == restart) start_i = 1'b1;
      if (restart > 0 && e == restart + 1) start_i = 1'b0;
      if (new_nom > 0 && e == 1) nominal_i = new_nom[11:0];
    end
    chk(e_done == d + 20, {"R5 done latency ", tag}, e_done, d + 20);
    chk(longint'(count_o) == exp_cnt, {"R2 count ", tag}, longint'(count_o), exp_cnt);
    chk(longint'(ratio_o) == exp_rat, {"R4 ratio ", tag}, longint'(ratio_o), exp_rat);
    @(negedge clk);
    chk(done_o == 1'b0, {"R5 single pulse ", tag}, done_o, 0);
    cmp_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // d <= 0 means no comparator edge at all
  task automatic overflow(input int nom, input int d, input string tag);
    int lim = 4 * nom;
    bit saw_done = 1'b0;
    @(negedge clk);
    nominal_i = nom[11:0];
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    for (int e = 1; e <= lim + 1; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (done_o) saw_done = 1'b1;
      if (d > 0 && e == d) cmp_i = 1'b1;
      if (e == lim) chk(ovf_o == 1'b0, {"R6 not early ", tag}, ovf_o, 0);
      if (e == lim + 1) begin
        chk(ovf_o == 1'b1, {"R6 ovf set ", tag}, ovf_o, 1);
        chk(longint'(count_o) == lim, {"R6 count at limit ", tag}, longint'(count_o), lim);
        chk(longint'(ratio_o) == 65535, {"R6 ratio saturated ", tag}, longint'(ratio_o), 65535);
      end
    end
    repeat (6) @(negedge clk);
    chk(saw_done == 1'b0 && done_o == 1'b0, {"R6 no done ", tag}, saw_done, 0);
    chk(ovf_o == 1'b1, {"R6 ovf held ", tag}, ovf_o, 1);
    cmp_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_unity();      measure(416, 413, 0, 0, 0, "unity");           endtask
  task automatic t_slow();       measure(416, 500, 0, 0, 0, "slow");            endtask
  task automatic t_fast();       measure(300, 100, 0, 0, 0, "fast");            endtask
  task automatic t_glitch();     measure(200, 60, 20, 0, 0, "R3 glitch");       endtask
  task automatic t_restart_cnt(); measure(100, 80, 0, 5, 0, "R7 start while counting"); endtask
  task automatic t_restart_div(); measure(100, 80, 0, 90, 0, "R7 start while dividing"); endtask
  task automatic t_nom_change(); measure(416, 300, 0, 0, 200, "R8 nominal change"); endtask
  task automatic t_edge_ok();    measure(10, 36, 0, 0, 0, "R6 last valid count"); endtask
  task automatic t_edge_ovf();   overflow(10, 37, "boundary");                  endtask
  task automatic t_no_cross();   overflow(25, 0, "no crossing");                endtask
  task automatic t_zero_nom();   overflow(0, 0, "zero nominal");                endtask
  task automatic t_after_ovf();  measure(20, 5, 0, 0, 0, "R9 after overflow");  endtask

  initial begin
    t_reset();
    t_unity();
    t_slow();
    t_fast();
    t_glitch();
    t_restart_cnt();
    t_restart_div();
    t_nom_change();
    t_edge_ok();
    t_edge_ovf();
    t_after_ovf();
    t_no_cross();
    t_zero_nom();
    t_after_ovf();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule